// File: doc/BRIEF.md
# Serial Flash Transaction Sequencer

This block runs one serial-flash transaction at a time. A 32-bit flag word, a 16-bit data count and a byte stream describe the transaction. The stream holds the opcode bytes first, then the address and alternate bytes, then the data to write when the transaction is a write. The sequencer breaks the transaction into phases and hands each phase to a multi-lane SPI shifter through a request/acknowledge handshake. For each phase it sets the chip select, the lane count, the direction and the dummy clock count. It pulses a strobe for every byte it takes from the stream and for every byte it reads back. The pin-level shifter sits outside this block.

Two optional sub-transactions can wrap a transaction. One is a write-enable command sent before the main transfer. The other is a busy-status poll sent after it. The poll repeats until the device reports ready or a round limit runs out. The same block also serves explicit chip-select commands from the host. Every command ends with a one-cycle `done` pulse that carries a 16-bit status.

States: IDLE, WREN (write-enable byte), WREN_GAP (chip select released), OPCODE, ADDR, DUMMY, DATA, POLL_GAP, POLL_OP, POLL_RD, DONE.

Transitions:
- IDLE→DONE on a chip-select command, or on a start whose flags are rejected.
- IDLE→WREN on an accepted start that requests write-enable.
- IDLE or WREN_GAP→the first non-empty phase, taken in the order OPCODE, ADDR, DUMMY, DATA, then POLL_GAP or DONE.
- WREN→WREN_GAP on ack.
- Each byte phase moves on at the acknowledge of its last byte. DUMMY moves on at its single acknowledge.
- POLL_GAP→POLL_OP→POLL_RD.
- POLL_RD→DONE on ready or on an expired limit, otherwise back to POLL_GAP.
- DONE→IDLE.

Top module: `sf_sequencer`

## Requirements
- R1: Flag bits 1:0 give the number of opcode bytes and bits 4:2 give the number of address/alternate bytes. Stream bytes go out one per acknowledged request, in order: opcode bytes, then address bytes, then write data. `buf_pop` is high exactly in the cycle a stream byte is acknowledged.
- R2: `sh_lanes` encodes the lane count as 0=1, 1=2, 2=4 and 3=8 lanes, with N taken from flag bits 8:7. Flag bits 6:5 pick the mode. Mode 0 uses one lane for every phase. Mode 1 uses N lanes for data only. Mode 2 uses N lanes for address and data. Mode 3 uses N lanes for every phase.
- R3: When flag bits 14:10 are nonzero, the sequencer issues one dummy request between the address phase and the data phase. That request has `sh_dummy`=1, `sh_dir`=0, `sh_ncyc` equal to the field, and the data-phase lane code.
- R4: Flag bit 31 selects read (0) or write (1). A write sends `count` data bytes from the stream with `sh_dir`=1. A read issues `count` receive requests with `sh_dir`=0, and each received byte appears on `rd_data` with `rd_valid`. A count of zero produces no data phase.
- R5: A start is rejected with status 0x000A when any of the following holds. When rejected, no shifter request is made and no stream byte is taken.
  - Any of flag bits 27:15 or bit 30 is set.
  - Bit 9 (double rate) is set.
  - The mode is nonzero and parameter `LANE_OK` lacks the requested width.
  
  A width that `LANE_OK` lacks is accepted in mode 0.
- R6: When flag bit 28 is set, a single byte 0x06 is sent on one lane first. After it, `cs_n` goes high for at least one clock before the main transfer begins.
- R7: When flag bit 29 is set, the sequencer polls the device after the main transfer. Each round:
  - holds `cs_n` high for at least one clock;
  - sends 0x05 on one lane;
  - reads one byte on one lane.
  
  Polling ends with status 0x0000 when bit 0 of the read byte is clear.
- R8: After `poll_max` rounds that each read bit 0 set, the transaction ends with status 0x0001. A `poll_max` of 0 ends after the first busy read.
- R9: A chip-select command with action 1 holds `cs_n` low and action 0 releases it, each answered with status 0x0000. Any other action value is answered with 0x0008 and leaves `cs_n` unchanged.
- R10: When `cs_cmd` and `start` are both high in an idle cycle, the chip-select command is served and the start is discarded.
- R11: A request is held, with its direction, lane code and dummy flag stable, until `sh_ack`. `cs_n` is low whenever a request is raised.
- R12: After reset, `cs_n` is high and `sh_req` and `done` are low. `done` is a one-cycle pulse with `status` valid in that cycle, and no request is raised while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transaction (sampled in IDLE) |
| flags | input | 32 | Transaction flag word |
| count | input | 16 | Number of data bytes |
| cs_cmd | input | 1 | Chip-select command (sampled in IDLE) |
| cs_action | input | 16 | Chip-select action: 1 assert, 0 release |
| poll_max | input | 16 | Busy-poll round limit |
| buf_data | input | 8 | Head byte of the transaction stream |
| buf_pop | output | 1 | Head byte consumed this cycle |
| rd_valid | output | 1 | Read data byte valid |
| rd_data | output | 8 | Read data byte |
| sh_req | output | 1 | Phase request to the shifter |
| sh_dummy | output | 1 | Request is a dummy-clock phase |
| sh_dir | output | 1 | 1 drive out, 0 receive |
| sh_lanes | output | 2 | Lane code: 0=1, 1=2, 2=4, 3=8 |
| sh_txd | output | 8 | Byte to send |
| sh_ncyc | output | 5 | Dummy clock count |
| sh_ack | input | 1 | Shifter finished the request |
| sh_rxd | input | 8 | Byte received by the shifter |
| cs_n | output | 1 | Active-low chip select |
| done | output | 1 | Command finished pulse |
| status | output | 16 | Completion status |

## Verification
A chip-select command and a transaction start can arrive in the same idle cycle. The bench provokes this by raising `cs_cmd` and `start` on the same clock, with a legal read flag word on the start. It then confirms three things:
- `done` arrives in the following cycle with the chip-select status.
- `cs_n` takes the commanded level.
- In the cycles after, the shifter receives no request and no stream byte is taken.

A reference model in the bench expects no shifter operation at all, so any request from the discarded start counts as a mismatch.

// File: rtl/sf_seq_pkg.sv
package sf_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WREN,
        ST_WREN_GAP,
        ST_OPCODE,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_POLL_GAP,
        ST_POLL_OP,
        ST_POLL_RD,
        ST_DONE
    } sf_state_e;

    typedef struct packed {
        logic [1:0] op_len;
        logic [2:0] adr_len;
        logic [1:0] op_lanes;
        logic [1:0] adr_lanes;
        logic [1:0] dat_lanes;
        logic [4:0] dummy;
        logic       wren;
        logic       poll;
        logic       write;
        logic       legal;
    } sf_cfg_t;

    localparam logic [15:0] SFS_OK      = 16'h0000;
    localparam logic [15:0] SFS_TIMEOUT = 16'h0001;
    localparam logic [15:0] SFS_BADCS   = 16'h0008;
    localparam logic [15:0] SFS_UNSUP   = 16'h000A;

    localparam logic [7:0] OPC_WREN = 8'h06;
    localparam logic [7:0] OPC_RDSR = 8'h05;

endpackage

// File: rtl/sf_seq_decode.sv
module sf_seq_decode
    import sf_seq_pkg::*;
#(
    parameter logic [3:0] LANE_OK = 4'b0111
) (
    input  logic [31:0] flags,
    output sf_cfg_t     cfg
);
    logic [1:0] mode;
    logic [1:0] wid;
    logic       rsv;

    always_comb begin
        mode = flags[6:5];
        wid  = flags[8:7];
        rsv  = (|flags[27:15]) | flags[30];
        cfg.op_len    = flags[1:0];
        cfg.adr_len   = flags[4:2];
        cfg.dummy     = flags[14:10];
        cfg.wren      = flags[28];
        cfg.poll      = flags[29];
        cfg.write     = flags[31];
        cfg.op_lanes  = (mode == 2'd3) ? wid : 2'd0;
        cfg.adr_lanes = (mode >= 2'd2) ? wid : 2'd0;
        cfg.dat_lanes = (mode != 2'd0) ? wid : 2'd0;
        cfg.legal     = !rsv && !flags[9] && ((mode == 2'd0) || LANE_OK[wid]);
    end
endmodule

// File: rtl/sf_seq_fsm.sv
module sf_seq_fsm
    import sf_seq_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int POLL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  sf_cfg_t           cfg_in,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic              cs_cmd,
    input  logic [15:0]       cs_action,
    input  logic [POLL_W-1:0] poll_max,
    input  logic [7:0]        buf_data,
    output logic              buf_pop,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              sh_req,
    output logic              sh_dummy,
    output logic              sh_dir,
    output logic [1:0]        sh_lanes,
    output logic [7:0]        sh_txd,
    output logic [4:0]        sh_ncyc,
    input  logic              sh_ack,
    input  logic [7:0]        sh_rxd,
    output logic              cs_n,
    output logic              done,
    output logic [15:0]       status
);
    sf_state_e          st_q, st_d;
    sf_cfg_t            cfg_q, cfg_c;
    logic [CNT_W-1:0]   dcnt_q, n_c, left_q;
    logic [POLL_W-1:0]  rnd_q;
    logic [POLL_W:0]    rnd_next;
    logic               poll_expire;
    logic [15:0]        stat_q;
    logic               hold_q;
    logic               seq_cs;
    logic               last_byte;

    assign cfg_c       = (st_q == ST_IDLE) ? cfg_in : cfg_q;
    assign n_c         = (st_q == ST_IDLE) ? cnt_in : dcnt_q;
    assign rnd_next    = {1'b0, rnd_q} + 1'b1;
    assign poll_expire = rnd_next >= {1'b0, poll_max};
    assign last_byte   = (left_q == CNT_W'(1));

    function automatic sf_state_e next_phase(input sf_state_e from, input sf_cfg_t c,
                                             input logic [CNT_W-1:0] n);
        logic pre_op, pre_adr, pre_dum, pre_dat;
        pre_op  = (from == ST_IDLE) || (from == ST_WREN_GAP);
        pre_adr = pre_op || (from == ST_OPCODE);
        pre_dum = pre_adr || (from == ST_ADDR);
        pre_dat = pre_dum || (from == ST_DUMMY);
        if (pre_op && c.op_len != 2'd0)       return ST_OPCODE;
        if (pre_adr && c.adr_len != 3'd0)     return ST_ADDR;
        if (pre_dum && c.dummy != 5'd0)       return ST_DUMMY;
        if (pre_dat && n != '0)               return ST_DATA;
        return c.poll ? ST_POLL_GAP : ST_DONE;
    endfunction

    function automatic logic [CNT_W-1:0] phase_len(input sf_state_e s, input sf_cfg_t c,
                                                   input logic [CNT_W-1:0] n);
        case (s)
            ST_OPCODE: return CNT_W'(c.op_len);
            ST_ADDR:   return CNT_W'(c.adr_len);
            ST_DATA:   return n;
            default:   return '0;
        endcase
    endfunction

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (cs_cmd)                st_d = ST_DONE;
                else if (start) begin
                    if (!cfg_in.legal)     st_d = ST_DONE;
                    else if (cfg_in.wren)  st_d = ST_WREN;
                    else                   st_d = next_phase(ST_IDLE, cfg_c, n_c);
                end
            end
            ST_WREN:     if (sh_ack) st_d = ST_WREN_GAP;
            ST_WREN_GAP: st_d = next_phase(ST_WREN_GAP, cfg_c, n_c);
            ST_OPCODE,
            ST_ADDR,
            ST_DATA:     if (sh_ack && last_byte) st_d = next_phase(st_q, cfg_c, n_c);
            ST_DUMMY:    if (sh_ack) st_d = next_phase(ST_DUMMY, cfg_c, n_c);
            ST_POLL_GAP: st_d = ST_POLL_OP;
            ST_POLL_OP:  if (sh_ack) st_d = ST_POLL_RD;
            ST_POLL_RD: begin
                if (sh_ack) begin
                    if (!sh_rxd[0] || poll_expire) st_d = ST_DONE;
                    else                           st_d = ST_POLL_GAP;
                end
            end
            ST_DONE:     st_d = ST_IDLE;
            default:     st_d = ST_IDLE;
        endcase
    end

    // state and context registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cfg_q  <= '0;
            dcnt_q <= '0;
            left_q <= '0;
            rnd_q  <= '0;
            stat_q <= SFS_OK;
            hold_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q != st_d)
                left_q <= phase_len(st_d, cfg_c, n_c);
            else if (sh_ack && sh_req && !sh_dummy)
                left_q <= left_q - 1'b1;
            if (st_q == ST_IDLE) begin
                if (cs_cmd) begin
                    if (cs_action == 16'd1)      begin hold_q <= 1'b1; stat_q <= SFS_OK; end
                    else if (cs_action == 16'd0) begin hold_q <= 1'b0; stat_q <= SFS_OK; end
                    else                         stat_q <= SFS_BADCS;
                end else if (start) begin
                    cfg_q  <= cfg_in;
                    dcnt_q <= cnt_in;
                    rnd_q  <= '0;
                    stat_q <= cfg_in.legal ? SFS_OK : SFS_UNSUP;
                end
            end
            if (st_q == ST_POLL_RD && sh_ack && sh_rxd[0]) begin
                rnd_q <= rnd_next[POLL_W-1:0];
                if (poll_expire) stat_q <= SFS_TIMEOUT;
            end
        end
    end

    // outputs
    always_comb begin
        sh_req   = 1'b0;
        sh_dummy = 1'b0;
        sh_dir   = 1'b0;
        sh_lanes = 2'd0;
        sh_txd   = 8'h00;
        sh_ncyc  = 5'd0;
        buf_pop  = 1'b0;
        rd_valid = 1'b0;
        seq_cs   = 1'b0;
        done     = 1'b0;
        unique case (st_q)
            ST_WREN: begin
                sh_req = 1'b1; sh_dir = 1'b1; sh_txd = OPC_WREN; seq_cs = 1'b1;
            end
            ST_OPCODE: begin
                sh_req = 1'b1; sh_dir = 1'b1; sh_lanes = cfg_q.op_lanes;
                sh_txd = buf_data; buf_pop = sh_ack; seq_cs = 1'b1;
            end
            ST_ADDR: begin
                sh_req = 1'b1; sh_dir = 1'b1; sh_lanes = cfg_q.adr_lanes;
                sh_txd = buf_data; buf_pop = sh_ack; seq_cs = 1'b1;
            end
            ST_DUMMY: begin
                sh_req = 1'b1; sh_dummy = 1'b1; sh_lanes = cfg_q.dat_lanes;
                sh_ncyc = cfg_q.dummy; seq_cs = 1'b1;
            end
            ST_DATA: begin
                sh_req   = 1'b1; sh_dir = cfg_q.write; sh_lanes = cfg_q.dat_lanes;
                sh_txd   = cfg_q.write ? buf_data : 8'h00;
                buf_pop  = sh_ack & cfg_q.write;
                rd_valid = sh_ack & ~cfg_q.write;
                seq_cs   = 1'b1;
            end
            ST_POLL_OP: begin
                sh_req = 1'b1; sh_dir = 1'b1; sh_txd = OPC_RDSR; seq_cs = 1'b1;
            end
            ST_POLL_RD: begin
                sh_req = 1'b1; seq_cs = 1'b1;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    assign cs_n    = ~(seq_cs | hold_q);
    assign rd_data = sh_rxd;
    assign status  = stat_q;
endmodule

// File: rtl/sf_sequencer.sv
module sf_sequencer
    import sf_seq_pkg::*;
#(
    parameter logic [3:0] LANE_OK = 4'b0111,
    parameter int         CNT_W   = 16,
    parameter int         POLL_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       flags,
    input  logic [CNT_W-1:0]  count,
    input  logic              cs_cmd,
    input  logic [15:0]       cs_action,
    input  logic [POLL_W-1:0] poll_max,
    input  logic [7:0]        buf_data,
    output logic              buf_pop,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              sh_req,
    output logic              sh_dummy,
    output logic              sh_dir,
    output logic [1:0]        sh_lanes,
    output logic [7:0]        sh_txd,
    output logic [4:0]        sh_ncyc,
    input  logic              sh_ack,
    input  logic [7:0]        sh_rxd,
    output logic              cs_n,
    output logic              done,
    output logic [15:0]       status
);
    sf_cfg_t cfg_w;

    sf_seq_decode #(.LANE_OK(LANE_OK)) u_dec (
        .flags (flags),
        .cfg   (cfg_w)
    );

    sf_seq_fsm #(.CNT_W(CNT_W), .POLL_W(POLL_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cfg_in    (cfg_w),
        .cnt_in    (count),
        .cs_cmd    (cs_cmd),
        .cs_action (cs_action),
        .poll_max  (poll_max),
        .buf_data  (buf_data),
        .buf_pop   (buf_pop),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .sh_req    (sh_req),
        .sh_dummy  (sh_dummy),
        .sh_dir    (sh_dir),
        .sh_lanes  (sh_lanes),
        .sh_txd    (sh_txd),
        .sh_ncyc   (sh_ncyc),
        .sh_ack    (sh_ack),
        .sh_rxd    (sh_rxd),
        .cs_n      (cs_n),
        .done      (done),
        .status    (status)
    );
endmodule

// File: rtl/sf_sequencer_chk.sv
module sf_sequencer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sh_req,
    input logic        sh_ack,
    input logic        sh_dir,
    input logic        sh_dummy,
    input logic [1:0]  sh_lanes,
    input logic        buf_pop,
    input logic        rd_valid,
    input logic        cs_n,
    input logic        done
);
    // R11
    req_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sh_req |-> !cs_n);

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_req && !sh_ack) |=> (sh_req && $stable(sh_dir) && $stable(sh_lanes) && $stable(sh_dummy)));

    // R1
    pop_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_pop |-> (sh_ack && sh_req && sh_dir && !sh_dummy));

    // R4
    rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (sh_ack && sh_req && !sh_dir && !sh_dummy));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !sh_req);
endmodule

bind sf_sequencer sf_sequencer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sh_req   (sh_req),
    .sh_ack   (sh_ack),
    .sh_dir   (sh_dir),
    .sh_dummy (sh_dummy),
    .sh_lanes (sh_lanes),
    .buf_pop  (buf_pop),
    .rd_valid (rd_valid),
    .cs_n     (cs_n),
    .done     (done)
);

// File: tb/tb_sf_sequencer.sv
module tb_sf_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] flags = '0;
    logic [15:0] count = '0;
    logic        cs_cmd = 1'b0;
    logic [15:0] cs_action = '0;
    logic [15:0] poll_max = '0;
    logic [7:0]  buf_data = '0;
    logic        buf_pop, rd_valid;
    logic [7:0]  rd_data;
    logic        sh_req, sh_dummy, sh_dir;
    logic [1:0]  sh_lanes;
    logic [7:0]  sh_txd;
    logic [4:0]  sh_ncyc;
    logic        sh_ack = 1'b0;
    logic [7:0]  sh_rxd = '0;
    logic        cs_n, done;
    logic [15:0] status;

    always #10 clk = ~clk;

    sf_sequencer dut (
        .clk(clk), .rst_n(rst_n), .start(start), .flags(flags), .count(count),
        .cs_cmd(cs_cmd), .cs_action(cs_action), .poll_max(poll_max),
        .buf_data(buf_data), .buf_pop(buf_pop), .rd_valid(rd_valid), .rd_data(rd_data),
        .sh_req(sh_req), .sh_dummy(sh_dummy), .sh_dir(sh_dir), .sh_lanes(sh_lanes),
        .sh_txd(sh_txd), .sh_ncyc(sh_ncyc), .sh_ack(sh_ack), .sh_rxd(sh_rxd),
        .cs_n(cs_n), .done(done), .status(status)
    );

    typedef struct {
        bit        dum;
        bit        dir;
        bit [1:0]  lanes;
        bit [7:0]  txd;
        bit [4:0]  ncyc;
        bit        gap;
        bit        pop;
        bit        isrd;
        bit [7:0]  rx;
        string     req;
    } op_t;

    op_t            expq[$];
    bit [7:0]       bufq[$];
    int             checks = 0;
    int             errors = 0;
    bit             cs_hi_seen = 1'b1;
    bit             ended = 1'b0;
    int             lat = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // shifter model and per-clock comparison against the expected operation queue
    initial begin
        forever begin
            @(negedge clk);
            if (cs_n) cs_hi_seen = 1'b1;
            if (!rst_n) continue;
            if (sh_ack) begin
                sh_ack = 1'b0;
            end else if (sh_req) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R5/R10", "unexpected shifter request", 1, 0);
                end else if (lat > 0) begin
                    lat--;
                end else begin
                    op_t o;
                    o = expq.pop_front();
                    check(sh_dummy == o.dum && sh_dir == o.dir && sh_lanes == o.lanes,
                          o.req, "phase dummy/dir/lanes",
                          {sh_dummy, sh_dir, sh_lanes}, {o.dum, o.dir, o.lanes});
                    if (o.dir && !o.dum)
                        check(sh_txd == o.txd, o.req, "sent byte", sh_txd, o.txd);
                    if (o.dum)
                        check(sh_ncyc == o.ncyc, o.req, "dummy cycles", sh_ncyc, o.ncyc);
                    check(!cs_n, "R11", "cs_n during request", cs_n, 0);
                    if (o.gap)
                        check(cs_hi_seen, o.req, "cs_n gap before phase", cs_hi_seen, 1);
                    sh_rxd = o.rx;
                    sh_ack = 1'b1;
                    cs_hi_seen = 1'b0;
                    lat = (checks % 3);
                    #5;
                    check(buf_pop == o.pop, "R1", "buf_pop strobe", buf_pop, o.pop);
                    check(rd_valid == o.isrd, "R4", "rd_valid strobe", rd_valid, o.isrd);
                    if (o.isrd)
                        check(rd_data == o.rx, "R4", "read byte", rd_data, o.rx);
                    if (buf_pop && bufq.size() > 0) void'(bufq.pop_front());
                    buf_data = (bufq.size() > 0) ? bufq[0] : 8'h00;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", "run did not finish", 0, 1);
        finish_run();
    end

    function automatic op_t mk(bit dum, bit dir, bit [1:0] ln, bit [7:0] tx, bit [4:0] nc,
                               bit gap, bit pop, bit isrd, bit [7:0] rx, string req);
        op_t o;
        o.dum = dum; o.dir = dir; o.lanes = ln; o.txd = tx; o.ncyc = nc; o.gap = gap;
        o.pop = pop; o.isrd = isrd; o.rx = rx; o.req = req;
        return o;
    endfunction

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (done) begin seen = 1'b1; break; end
        end
    endtask

    // Build expectations from the requirements and run one transaction.
    task automatic txn(input bit [31:0] f, input int n, input bit [7:0] pollr[$],
                       input int pmax, input string tag);
        bit [1:0] mode = f[6:5];
        bit [1:0] wid  = f[8:7];
        bit [3:0] lane_ok = 4'b0111;
        bit       legal;
        bit [1:0] opl, adl, dtl;
        int       olen = f[1:0];
        int       alen = f[4:2];
        int       dcyc = f[14:10];
        bit       wr = f[31];
        bit       gap_next = 1'b0;
        bit [15:0] exp_st = 16'h0000;
        int       k = 0;
        bit       seen;
        legal = (f[27:15] == 0) && !f[30] && !f[9] && (mode == 0 || lane_ok[wid]);
        opl = (mode == 3) ? wid : 2'd0;
        adl = (mode >= 2) ? wid : 2'd0;
        dtl = (mode != 0) ? wid : 2'd0;
        if (!legal) begin
            exp_st = 16'h000A;
            bufq.push_back(8'h5A);
        end else begin
            int total = olen + alen + (wr ? n : 0);
            for (int i = 0; i < total; i++) bufq.push_back(8'h30 + 8'(i) + 8'(tag.len()));
            if (f[28]) begin
                expq.push_back(mk(0, 1, 0, 8'h06, 0, 0, 0, 0, 0, "R6"));
                gap_next = 1'b1;
            end
            for (int i = 0; i < olen; i++) begin
                expq.push_back(mk(0, 1, opl, bufq[k], 0, gap_next, 1, 0, 0, "R1/R2"));
                k++; gap_next = 1'b0;
            end
            for (int i = 0; i < alen; i++) begin
                expq.push_back(mk(0, 1, adl, bufq[k], 0, gap_next, 1, 0, 0, "R1/R2"));
                k++; gap_next = 1'b0;
            end
            if (dcyc != 0) begin
                expq.push_back(mk(1, 0, dtl, 0, 5'(dcyc), gap_next, 0, 0, 0, "R3"));
                gap_next = 1'b0;
            end
            for (int i = 0; i < n; i++) begin
                if (wr) begin
                    expq.push_back(mk(0, 1, dtl, bufq[k], 0, gap_next, 1, 0, 0, "R4"));
                    k++;
                end else begin
                    expq.push_back(mk(0, 0, dtl, 0, 0, gap_next, 0, 1, 8'hC0 ^ 8'(i), "R4"));
                end
                gap_next = 1'b0;
            end
            if (f[29]) begin
                for (int r = 0; r < pollr.size(); r++) begin
                    expq.push_back(mk(0, 1, 0, 8'h05, 0, 1, 0, 0, 0, "R7"));
                    expq.push_back(mk(0, 0, 0, 0, 0, 0, 0, 0, pollr[r], "R7"));
                    if (!pollr[r][0]) begin exp_st = 16'h0000; break; end
                    if (r + 1 >= pmax) begin exp_st = 16'h0001; break; end
                end
            end
        end
        buf_data = (bufq.size() > 0) ? bufq[0] : 8'h00;
        flags = f; count = 16'(n); poll_max = 16'(pmax); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (done) seen = 1'b1; else wait_done(seen);
        check(seen, tag, "done pulse seen", seen, 1);
        check(status == exp_st, tag, "completion status", status, exp_st);
        check(expq.size() == 0, tag, "all expected phases issued", expq.size(), 0);
        if (!legal) begin
            check(bufq.size() == 1, "R5", "stream untouched on reject", bufq.size(), 1);
            bufq.delete();
        end else begin
            check(bufq.size() == 0, "R1", "stream fully consumed", bufq.size(), 0);
        end
        @(negedge clk);
        check(!done, "R12", "done is one cycle", done, 0);
        check(cs_n, tag, "cs_n released after transaction", cs_n, 1);
    endtask

    task automatic cs_command(input bit [15:0] act, input bit [15:0] exp_st,
                              input bit exp_csn, input bit with_start, input string tag);
        cs_action = act; cs_cmd = 1'b1;
        if (with_start) begin flags = 32'h0000_000D; count = 16'd4; start = 1'b1; end
        @(negedge clk);
        cs_cmd = 1'b0; start = 1'b0;
        check(done, tag, "done after cs command", done, 1);
        check(status == exp_st, tag, "cs command status", status, exp_st);
        check(cs_n == exp_csn, tag, "cs_n level", cs_n, exp_csn);
        repeat (6) @(negedge clk);
        check(!done, tag, "no further completion", done, 0);
        check(cs_n == exp_csn, tag, "cs_n held", cs_n, exp_csn);
    endtask

    initial begin
        bit [7:0] none[$];
        bit [7:0] p_ok[$];
        bit [7:0] p_busy[$];
        p_ok   = '{8'h03, 8'h01, 8'h00};
        p_busy = '{8'h01, 8'hFF, 8'h01, 8'h01};
        repeat (3) @(negedge clk);
        // R12 reset state
        check(cs_n == 1'b1, "R12", "cs_n in reset", cs_n, 1);
        check(sh_req == 1'b0, "R12", "sh_req in reset", sh_req, 0);
        check(done == 1'b0, "R12", "done in reset", done, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 R2 single-lane read, 1 opcode + 3 address bytes, 4 data
        txn(32'h0000_000D, 4, none, 4, "R1");
        // R2 R4 R6 R7 quad data write with write-enable and busy poll
        txn(32'h0000_000D | (1 << 5) | (2 << 7) | (1 << 28) | (1 << 29) | (1 << 31),
            5, p_ok, 8, "R7");
        // R2 R3 dual address+data read with 8 dummy cycles
        txn(32'h0000_000D | (2 << 5) | (1 << 7) | (8 << 10), 3, none, 4, "R3");
        // R4 quad all phases, write with zero count
        txn(32'h0000_0001 | (3 << 5) | (2 << 7) | (1 << 31), 0, none, 4, "R4");
        // R3 no opcode, no address, dummy then read
        txn(32'h0000_0000 | (4 << 10), 2, none, 4, "R3");
        // R5 rejections
        txn(32'h0000_000D | (1 << 20), 2, none, 4, "R5");
        txn(32'h0000_000D | (1 << 30), 2, none, 4, "R5");
        txn(32'h0000_000D | (1 << 9), 2, none, 4, "R5");
        txn(32'h0000_000D | (1 << 5) | (3 << 7), 2, none, 4, "R5");
        // R5 eight-lane width accepted in mode 0
        txn(32'h0000_0005 | (3 << 7), 2, none, 4, "R5");
        // R8 poll timeout after two busy rounds
        txn(32'h0000_0001 | (1 << 29) | (1 << 31), 1, p_busy, 2, "R8");
        // R8 zero limit ends after the first busy read
        txn(32'h0000_0001 | (1 << 29), 0, p_busy, 0, "R8");
        // R9 chip-select commands
        cs_command(16'd1, 16'h0000, 1'b0, 1'b0, "R9");
        cs_command(16'd7, 16'h0008, 1'b0, 1'b0, "R9");
        cs_command(16'd0, 16'h0000, 1'b1, 1'b0, "R9");
        cs_command(16'd2, 16'h0008, 1'b1, 1'b0, "R9");
        // R10 cs command and start in the same cycle
        cs_command(16'd1, 16'h0000, 1'b0, 1'b1, "R10");
        cs_command(16'd0, 16'h0000, 1'b1, 1'b1, "R10");
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule